// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a three-wire configuration link: an active-low select, a serial clock and one data line that the host drives during writes and the block drives during reads. It sits in front of a bank of thirty 8-bit control registers held elsewhere on the chip. The block decodes the command octet, streams data octets to and from the register bank, and tells the bank when staged values must be applied.

The block runs on the chip's system clock. The three serial pins are resynchronised and their edges are detected internally. The first octet of every session carries a 7-bit register address, most significant bit first, followed by a direction bit. Each further octet moves 8 bits to or from the current address, and the address then steps upward. The transmit buffer address is the exception: it holds still, so that one session can stream any number of bytes into it. Writes to the sync-word registers and to the buffer are marked as taking effect at once. Every other write is staged until the select line is released, and the block then issues a one-cycle apply pulse.

Reads use a combinational lookup. The block presents an address on `rdAddr` and takes the byte returned on `rdData`. A read session never raises a write strobe.

Top module: `serial_cfg_port`

## Requirements
- R1: A session begins when `serEnN` falls. The first octet is taken as a 7-bit address, most significant bit first, followed by one direction bit, where 1 selects read and 0 selects write.
- R2: Input bits are captured on falling edges of `serClk`. In a read session each data bit, most significant bit first, is placed on `serDout` after a rising edge of `serClk`, so it is valid for the following falling edge.
- R3: In a write session each completed data octet raises `wrEn` for one cycle, with `wrAddr` and `wrData`. The first octet goes to the command address, and each later octet goes to the address one higher than the one before.
- R4: While the current address is 29 (the transmit buffer), completing an octet leaves the address at 29. This holds for both reads and writes.
- R5: `wrLive` is 1 with a write to addresses 25 to 29 and 0 with a write to any other address.
- R6: `loadPulse` rises for exactly one cycle, a few cycles after `serEnN` rises, only if the session completed a write to an address outside 25 to 29. Sessions that are read-only or live-only, and sessions with no completed write, give no pulse.
- R7: A read session returns consecutive registers starting at the command address, and it raises no `wrEn` and no `loadPulse`.
- R8: An octet cut short by `serEnN` rising is discarded. The bit position restarts at the first bit of the command octet on every fall of `serEnN`.
- R9: `serDoutEn` is 1 only during the data phase of a read session. It is 0 in the command octet, in write sessions and while the block is deselected.
- R10: Addresses 30 and above are outside the bank. Writes to them raise no `wrEn` and no `loadPulse`, and reads from them return 0x00.
- R11: After reset `wrEn`, `loadPulse`, `serDoutEn` and `serDout` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serEnN | input | 1 | Serial select, active low |
| serClk | input | 1 | Serial clock from the host |
| serDin | input | 1 | Serial data from the host |
| serDout | output | 1 | Serial read data to the host |
| serDoutEn | output | 1 | Drive enable for the shared data line |
| rdAddr | output | 7 | Register address for read-back |
| rdData | input | 8 | Register contents at `rdAddr` |
| wrEn | output | 1 | One-cycle write strobe |
| wrAddr | output | 7 | Address of the write |
| wrData | output | 8 | Data of the write |
| wrLive | output | 1 | The write takes effect at once, with no apply pulse |
| loadPulse | output | 1 | Apply staged values, one cycle |

## Verification
The bench builds the block with its default parameters: 7-bit addresses, 8-bit data, 30 registers, the buffer at 29, the immediate-effect window at 25 to 28 and two synchroniser stages. With these values a single 30-byte read burst covers every register. A write burst from 27 crosses the boundary into the buffer and then holds there. Addresses 31 and 40 reach the out-of-range path. The serial clock is held at eight system cycles per half period, which leaves room for synchroniser latency, and lets outputs be sampled late in each half period.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } srpState_t;

  // strobes from control to datapath, all one cycle wide
  typedef struct packed {
    logic sessStart;
    logic shiftBit;
    logic takeCmd;
    logic commit;
    logic advance;
    logic loadTx;
    logic shiftTx;
  } srpStrobe_t;

  // decoded view of the current address and direction
  typedef struct packed {
    logic isRead;
    logic inRange;
    logic isLive;
    logic atBuffer;
  } srpStatus_t;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/srp_ctl.sv
module srp_ctl
  import srp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enLvl,
  input  logic       sckLvl,
  input  srpStatus_t status,
  output srpStrobe_t strobe,
  output logic       doutEn,
  output logic       loadPulse
);

  localparam int               BIT_W    = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  srpState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic             prevEn, prevSck;
  logic             deferredSeen;
  logic             enFall, enRise, sckFall, sckRise;
  logic             active, octetDone, readData;

  assign enFall  = prevEn & ~enLvl;
  assign enRise  = ~prevEn & enLvl;
  assign sckFall = prevSck & ~sckLvl;
  assign sckRise = ~prevSck & sckLvl;

  assign active    = (state != ST_IDLE) && !enRise && !enFall;
  assign octetDone = strobe.shiftBit && (bitCnt == LAST_BIT);
  assign readData  = (state == ST_DATA) && status.isRead;

  always_comb begin
    strobe           = '0;
    strobe.sessStart = enFall;
    strobe.shiftBit  = sckFall && active;
    strobe.takeCmd   = octetDone && (state == ST_CMD);
    strobe.commit    = octetDone && (state == ST_DATA) && !status.isRead && status.inRange;
    strobe.advance   = octetDone && (state == ST_DATA) && !status.atBuffer;
    strobe.loadTx    = sckRise && active && readData && (bitCnt == '0);
    strobe.shiftTx   = sckRise && active && readData && (bitCnt != '0);
  end

  assign doutEn = readData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bitCnt       <= '0;
      prevEn       <= 1'b1;
      prevSck      <= 1'b0;
      deferredSeen <= 1'b0;
      loadPulse    <= 1'b0;
    end else begin
      prevEn  <= enLvl;
      prevSck <= sckLvl;
      if (enFall) begin
        state        <= ST_CMD;
        bitCnt       <= '0;
        deferredSeen <= 1'b0;
        loadPulse    <= 1'b0;
      end else if (enRise) begin
        state        <= ST_IDLE;
        bitCnt       <= '0;
        loadPulse    <= deferredSeen;
        deferredSeen <= 1'b0;
      end else begin
        loadPulse <= 1'b0;
        if (strobe.shiftBit) bitCnt <= bitCnt + 1'b1;
        if (strobe.takeCmd) state <= ST_DATA;
        if (strobe.commit && !status.isLive) deferredSeen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/srp_dp.sv
module srp_dp
  import srp_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 30,
  parameter int BUF_ADDR = 29,
  parameter int LIVE_LO  = 25,
  parameter int LIVE_HI  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dinLvl,
  input  srpStrobe_t        strobe,
  input  logic [DATA_W-1:0] rdData,
  output srpStatus_t        status,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              dout,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrLive
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] BUF_A     = ADDR_W'(BUF_ADDR);
  localparam logic [ADDR_W-1:0] LIVE_LO_A = ADDR_W'(LIVE_LO);
  localparam logic [ADDR_W-1:0] LIVE_HI_A = ADDR_W'(LIVE_HI);

  logic [DATA_W-1:0] rxShift, rxByte, txShift, rdVal;
  logic [ADDR_W-1:0] addrReg;
  logic              isRead;

  assign rxByte = {rxShift[DATA_W-2:0], dinLvl};
  assign rdAddr = addrReg;

  assign status.isRead   = isRead;
  assign status.inRange  = addrReg <= LAST_ADDR;
  assign status.atBuffer = addrReg == BUF_A;
  assign status.isLive   = ((addrReg >= LIVE_LO_A) && (addrReg <= LIVE_HI_A)) || (addrReg == BUF_A);

  assign rdVal = status.inRange ? rdData : '0;

  // command octet, address and receive shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      addrReg <= '0;
      isRead  <= 1'b0;
    end else if (strobe.sessStart) begin
      rxShift <= '0;
      isRead  <= 1'b0;
    end else begin
      if (strobe.shiftBit) rxShift <= rxByte;
      if (strobe.takeCmd) begin
        addrReg <= rxByte[DATA_W-1:1];
        isRead  <= rxByte[0];
      end else if (strobe.advance) begin
        addrReg <= addrReg + 1'b1;
      end
    end
  end

  // write strobe towards the register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      wrLive <= 1'b0;
    end else begin
      wrEn <= strobe.commit;
      if (strobe.commit) begin
        wrAddr <= addrReg;
        wrData <= rxByte;
        wrLive <= status.isLive;
      end
    end
  end

  // read-back transmit shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '0;
      dout    <= 1'b0;
    end else if (strobe.loadTx) begin
      dout    <= rdVal[DATA_W-1];
      txShift <= {rdVal[DATA_W-2:0], 1'b0};
    end else if (strobe.shiftTx) begin
      dout    <= txShift[DATA_W-1];
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import srp_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 30,
  parameter int BUF_ADDR    = 29,
  parameter int LIVE_LO     = 25,
  parameter int LIVE_HI     = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serEnN,
  input  logic              serClk,
  input  logic              serDin,
  output logic              serDout,
  output logic              serDoutEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrLive,
  output logic              loadPulse
);

  logic [2:0] pinSync;
  srpStrobe_t strobe;
  srpStatus_t status;

  srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({serEnN, serClk, serDin}),
    .syncOut(pinSync)
  );

  srp_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .enLvl(pinSync[2]), .sckLvl(pinSync[1]),
    .status(status), .strobe(strobe),
    .doutEn(serDoutEn), .loadPulse(loadPulse)
  );

  srp_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .BUF_ADDR(BUF_ADDR), .LIVE_LO(LIVE_LO), .LIVE_HI(LIVE_HI)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .dinLvl(pinSync[0]), .strobe(strobe), .rdData(rdData),
    .status(status), .rdAddr(rdAddr), .dout(serDout),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrLive(wrLive)
  );

endmodule

// File: rtl/srp_checker.sv
module srp_checker
  import srp_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 30,
  parameter int LIVE_LO  = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              serDoutEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrLive,
  input logic              loadPulse,
  input logic [ADDR_W-1:0] rdAddr,
  input srpStrobe_t        strobe,
  input srpStatus_t        status
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] LIVE_LO_A = ADDR_W'(LIVE_LO);

  a_r7_no_write_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrEn, serDoutEn}));

  a_r6_load_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    loadPulse |=> !loadPulse);

  a_r9_no_drive_at_apply: assert property (@(posedge clk) disable iff (!rst_n)
    loadPulse |-> !serDoutEn);

  a_r10_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (wrAddr <= LAST_ADDR));

  a_r5_deferred_below_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrLive) |-> (wrAddr < LIVE_LO_A));

  a_r4_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && status.atBuffer) |=> status.atBuffer);

  a_r3_address_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !status.atBuffer) |=> (rdAddr == ADDR_W'($past(rdAddr) + 1'b1)));

endmodule

bind serial_cfg_port srp_checker #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .LIVE_LO(LIVE_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .serDoutEn(serDoutEn), .wrEn(wrEn),
  .wrAddr(wrAddr), .wrLive(wrLive), .loadPulse(loadPulse),
  .rdAddr(rdAddr), .strobe(strobe), .status(status)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serEnN = 1'b1, serClk = 1'b0, serDin = 1'b0;
  logic       serDout, serDoutEn, wrEn, wrLive, loadPulse;
  logic [6:0] rdAddr, wrAddr;
  logic [7:0] rdData, wrData;

  logic [7:0] bankMem [128];
  logic [6:0] wAddrLog [64];
  logic [7:0] wDataLog [64];
  logic       wLiveLog [64];
  int         wCnt = 0, lpCnt = 0;
  int         nChecks = 0, nFail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign rdData = bankMem[rdAddr];

  serial_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .serEnN(serEnN), .serClk(serClk), .serDin(serDin),
    .serDout(serDout), .serDoutEn(serDoutEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrLive(wrLive), .loadPulse(loadPulse)
  );

  always @(posedge clk) begin
    if (wrEn && wCnt < 64) begin
      wAddrLog[wCnt] = wrAddr;
      wDataLog[wCnt] = wrData;
      wLiveLog[wCnt] = wrLive;
      wCnt = wCnt + 1;
    end
    if (loadPulse) lpCnt = lpCnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic startSess();
    serEnN = 1'b0;
    waitHalf();
  endtask

  task automatic endSess();
    waitHalf();
    serEnN = 1'b1;
    repeat (4) waitHalf();
  endtask

  task automatic xferBit(input logic b, output logic r);
    serDin = b;
    serClk = 1'b1;
    waitHalf();
    r = serDout;
    serClk = 1'b0;
    waitHalf();
  endtask

  task automatic xferByte(input logic [7:0] b, output logic [7:0] r);
    logic bit_r;
    for (int i = 7; i >= 0; i--) begin
      xferBit(b[i], bit_r);
      r[i] = bit_r;
    end
  endtask

  task automatic sendCmd(input logic [6:0] a, input logic rd);
    logic [7:0] junk;
    xferByte({a, rd}, junk);
  endtask

  task automatic testReset();
    chk(wrEn == 0, "R11 wrEn", wrEn, 0);
    chk(loadPulse == 0, "R11 loadPulse", loadPulse, 0);
    chk(serDoutEn == 0, "R11 serDoutEn", serDoutEn, 0);
    chk(serDout == 0, "R11 serDout", serDout, 0);
  endtask

  // R1 R3 R5 R6 R9: deferred burst write from address 3
  task automatic testBurstWrite();
    logic [7:0] junk;
    logic [7:0] vals [3] = '{8'hA1, 8'hB2, 8'hC3};
    int w0 = wCnt, l0 = lpCnt;
    startSess();
    sendCmd(7'd3, 1'b0);
    for (int i = 0; i < 3; i++) begin
      xferByte(vals[i], junk);
      chk(serDoutEn == 0, "R9 no drive in write", serDoutEn, 0);
    end
    chk(lpCnt == l0, "R6 no apply before release", lpCnt - l0, 0);
    endSess();
    chk(wCnt - w0 == 3, "R3 strobe count", wCnt - w0, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wAddrLog[w0+i] == 7'(3 + i), "R3 burst address", wAddrLog[w0+i], 3 + i);
      chk(wDataLog[w0+i] == vals[i], "R1 burst data", wDataLog[w0+i], vals[i]);
      chk(wLiveLog[w0+i] == 0, "R5 deferred flag", wLiveLog[w0+i], 0);
    end
    chk(lpCnt - l0 == 1, "R6 one apply pulse", lpCnt - l0, 1);
  endtask

  // R4 R5 R6: stream across the sync words into the buffer
  task automatic testBufferStream();
    logic [7:0] junk;
    int w0 = wCnt, l0 = lpCnt;
    startSess();
    sendCmd(7'd27, 1'b0);
    for (int i = 0; i < 5; i++) xferByte(8'(8'h11 * (i + 1)), junk);
    endSess();
    chk(wCnt - w0 == 5, "R4 stream count", wCnt - w0, 5);
    for (int i = 0; i < 5; i++) begin
      int ea = (27 + i > 29) ? 29 : 27 + i;
      chk(wAddrLog[w0+i] == 7'(ea), "R4 buffer address", wAddrLog[w0+i], ea);
      chk(wDataLog[w0+i] == 8'(8'h11 * (i + 1)), "R4 stream data", wDataLog[w0+i], 8'h11 * (i + 1));
      chk(wLiveLog[w0+i] == 1, "R5 live flag", wLiveLog[w0+i], 1);
    end
    chk(lpCnt == l0, "R6 no apply for live writes", lpCnt - l0, 0);
  endtask

  // R2 R7 R9: full read burst
  task automatic testReadBurst(input logic [6:0] a0, input int n);
    logic [7:0] got;
    int w0 = wCnt, l0 = lpCnt;
    startSess();
    chk(serDoutEn == 0, "R9 quiet in command", serDoutEn, 0);
    sendCmd(a0, 1'b1);
    for (int i = 0; i < n; i++) begin
      int ea = (a0 + i > 29) ? 29 : a0 + i;
      xferByte(8'h00, got);
      chk(got == bankMem[ea], "R2 read data", got, bankMem[ea]);
      chk(serDoutEn == 1, "R9 drive in read", serDoutEn, 1);
    end
    endSess();
    chk(serDoutEn == 0, "R9 quiet after session", serDoutEn, 0);
    chk(wCnt == w0, "R7 no write in read", wCnt - w0, 0);
    chk(lpCnt == l0, "R7 no apply in read", lpCnt - l0, 0);
  endtask

  // R8: cut-short octets
  task automatic testPartial();
    logic r;
    logic [7:0] junk;
    int w0 = wCnt, l0 = lpCnt;
    startSess();
    for (int i = 0; i < 3; i++) xferBit(1'b1, r);
    endSess();
    startSess();
    sendCmd(7'd10, 1'b0);
    for (int i = 0; i < 5; i++) xferBit(1'b1, r);
    endSess();
    chk(wCnt == w0, "R8 partial dropped", wCnt - w0, 0);
    chk(lpCnt == l0, "R8 no apply for partial", lpCnt - l0, 0);
    startSess();
    sendCmd(7'd12, 1'b0);
    xferByte(8'h3C, junk);
    for (int i = 0; i < 4; i++) xferBit(1'b0, r);
    endSess();
    chk(wCnt - w0 == 1, "R8 restart count", wCnt - w0, 1);
    chk(wAddrLog[w0] == 7'd12, "R8 restart address", wAddrLog[w0], 12);
    chk(wDataLog[w0] == 8'h3C, "R8 restart data", wDataLog[w0], 8'h3C);
    chk(lpCnt - l0 == 1, "R6 apply after full octet", lpCnt - l0, 1);
  endtask

  // R10: addresses outside the bank
  task automatic testOutOfRange();
    logic [7:0] got;
    int w0 = wCnt, l0 = lpCnt;
    startSess();
    sendCmd(7'd40, 1'b0);
    xferByte(8'h77, got);
    endSess();
    chk(wCnt == w0, "R10 no write out of range", wCnt - w0, 0);
    chk(lpCnt == l0, "R10 no apply out of range", lpCnt - l0, 0);
    startSess();
    sendCmd(7'd31, 1'b1);
    xferByte(8'h00, got);
    endSess();
    chk(got == 8'h00, "R10 read zero", got, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) bankMem[i] = 8'((i * 37 + 11) ^ 8'h5A);
    repeat (5) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testBurstWrite();
    testBufferStream();
    testReadBurst(7'd0, 30);
    testReadBurst(7'd28, 3);
    testPartial();
    testOutOfRange();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule